// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This controller sits between a clocked request port and an external asynchronous static RAM. The RAM holds 524,288 bytes and has 19 address lines, an 8-bit shared data bus and three active-low strobes: chip select, write strobe and output enable. A client presents one request at a time with `req_valid`: a write flag, an address and write data. The request is taken on a clock edge where `req_ready` is high. The controller then drives the strobes and address pins through a fixed sequence. For a read it captures the returned byte, and it raises `rsp_done` for one cycle. It accepts nothing new until every hold, recovery and turnaround interval has run out.

All timing limits are parameters in nanoseconds. Each is turned into a cycle count at elaboration: the time is divided by `CLK_NS` and rounded up, with a floor of one cycle. With the defaults (8 ns clock), a read holds the strobes active for 4 cycles and then idles the bus for 2. A write strobe lasts 3 cycles, the data is held for 1 more cycle, and a 1-cycle recovery follows. The pad-side data bus is split into `sram_dq_out`, `sram_dq_in` and a drive enable `sram_dq_oe`, for a pad cell outside this block.

The sequencer has six states. S_IDLE waits for a request. S_RD_ACCESS holds chip select and output enable low. S_RD_TURN releases the bus. S_WR_STROBE holds the write strobe low while driving data. S_WR_HOLD raises the write strobe but keeps the data driven. S_WR_GAP is write recovery. The transitions are: S_IDLE→S_RD_ACCESS or S_IDLE→S_WR_STROBE on an accepted request; S_RD_ACCESS→S_RD_TURN, S_RD_TURN→S_IDLE, S_WR_STROBE→S_WR_HOLD, S_WR_HOLD→S_WR_GAP and S_WR_GAP→S_IDLE, each when the interval counter reaches zero.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and whenever idle, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are all 1, `sram_dq_oe` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: A read taken at edge E drives `sram_ce_n`=0, `sram_oe_n`=0, `sram_we_n`=1 and `sram_dq_oe`=0 for N_RD cycles after E. N_RD = max(ceil(T_ACC_NS/CLK_NS), ceil(T_CYC_NS/CLK_NS)), which is 4 by default.
- R3: The read byte is sampled from `sram_dq_in` at the edge that ends the last access cycle. It appears on `rsp_rdata` in the next cycle, and `rsp_done` is 1 in that same cycle.
- R4: After a read access all strobes are 1 and `sram_dq_oe` is 0 for N_TURN = ceil(T_OEZ_NS/CLK_NS) cycles (2 by default) before the controller is ready again.
- R5: A write taken at edge E drives `sram_ce_n`=0, `sram_we_n`=0, `sram_oe_n`=1 and `sram_dq_oe`=1, with the request data on `sram_dq_out`, for N_WP cycles. N_WP = max of the rounded-up strobe width, data setup and address-to-strobe-end times, which is 3 by default.
- R6: After the write strobe rises, `sram_ce_n` stays 0 and the data stays driven for N_DH = ceil(T_DH_NS/CLK_NS) cycles (1 by default). `rsp_done` is 1 in the first of these cycles.
- R7: A write ends with N_GAP cycles in which all strobes are 1 and the bus is not driven. N_GAP = max(ceil(T_WREC_NS/CLK_NS), N_CYC-N_WP-N_DH, 1), which is 1 by default.
- R8: `sram_dq_oe` is never 1 while `sram_oe_n` is 0, and output enable is never low unless chip select is low and the write strobe is high.
- R9: `req_ready` is 1 only in S_IDLE. A request presented while `req_ready` is 0 has no effect on the pins or on the memory contents.
- R10: `sram_addr` holds the accepted address and does not change while `sram_ce_n` stays low.
- R11: `rsp_done` is a single-cycle pulse, issued once per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller can take a request |
| rsp_rdata | output | 8 | Last captured read byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| sram_addr | output | 19 | Address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_in | input | 8 | Data returned from the RAM |

## Verification
The assertions assume the reset is applied before the first request and that `req_write`, `req_addr` and `req_wdata` are stable while `req_valid` is high at an accepting edge. The stimulus drives every input on the falling clock edge and holds each request for exactly one accepting edge.

The bench's RAM model returns valid data only after output enable has been active for the full access count; before that it returns a marker byte. A read captured too early therefore shows up as a data mismatch. Requests presented while the controller is busy carry a write to a fresh address. A later read of that address shows whether the request was truly ignored.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ACCESS,
        S_RD_TURN,
        S_WR_STROBE,
        S_WR_HOLD,
        S_WR_GAP
    } ctl_state_e;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        return max2(max2(a, b), c);
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            dq_out   <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture) begin
            rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int N_RD   = 4,
    parameter int N_TURN = 2,
    parameter int N_WP   = 3,
    parameter int N_DH   = 1,
    parameter int N_GAP  = 1,
    parameter int CNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output logic             done,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             drv
);

    ctl_state_e state_q, state_nx;
    logic       done_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_nx;
            done    <= done_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        done_nx  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_nx = S_WR_STROBE;
                        tmr_val  = CNT_W'(N_WP - 1);
                    end else begin
                        state_nx = S_RD_ACCESS;
                        tmr_val  = CNT_W'(N_RD - 1);
                    end
                end
            end
            S_RD_ACCESS: begin
                if (tmr_zero) begin
                    capture  = 1'b1;
                    done_nx  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_TURN - 1);
                    state_nx = S_RD_TURN;
                end
            end
            S_RD_TURN: begin
                if (tmr_zero) state_nx = S_IDLE;
            end
            S_WR_STROBE: begin
                if (tmr_zero) begin
                    done_nx  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_DH - 1);
                    state_nx = S_WR_HOLD;
                end
            end
            S_WR_HOLD: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_GAP - 1);
                    state_nx = S_WR_GAP;
                end
            end
            S_WR_GAP: begin
                if (tmr_zero) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        ce_n  = 1'b1;
        we_n  = 1'b1;
        oe_n  = 1'b1;
        drv   = 1'b0;
        ready = 1'b0;
        unique case (state_q)
            S_IDLE:      ready = 1'b1;
            S_RD_ACCESS: begin
                ce_n = 1'b0;
                oe_n = 1'b0;
            end
            S_RD_TURN:   ;
            S_WR_STROBE: begin
                ce_n = 1'b0;
                we_n = 1'b0;
                drv  = 1'b1;
            end
            S_WR_HOLD: begin
                ce_n = 1'b0;
                drv  = 1'b1;
            end
            S_WR_GAP:    ;
            default:     ;
        endcase
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 8,
    parameter int T_ACC_NS   = 25,
    parameter int T_CYC_NS   = 20,
    parameter int T_OEZ_NS   = 10,
    parameter int T_WP_NS    = 20,
    parameter int T_AW_NS    = 20,
    parameter int T_DS_NS    = 15,
    parameter int T_DH_NS    = 2,
    parameter int T_WREC_NS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int N_CYC  = ns_to_cyc(T_CYC_NS, CLK_NS);
    localparam int N_RD   = max2(ns_to_cyc(T_ACC_NS, CLK_NS), N_CYC);
    localparam int N_TURN = ns_to_cyc(T_OEZ_NS, CLK_NS);
    localparam int N_WP   = max3(ns_to_cyc(T_WP_NS, CLK_NS),
                                 ns_to_cyc(T_AW_NS, CLK_NS),
                                 ns_to_cyc(T_DS_NS, CLK_NS));
    localparam int N_DH   = ns_to_cyc(T_DH_NS, CLK_NS);
    localparam int N_GAP  = max3(ns_to_cyc(T_WREC_NS, CLK_NS), N_CYC - N_WP - N_DH, 1);
    localparam int N_MAX  = max3(max2(N_RD, N_TURN), max2(N_WP, N_DH), N_GAP);
    localparam int CNT_W  = $clog2(N_MAX + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             accept;
    logic             capture;

    sram_ctl_fsm #(
        .N_RD   (N_RD),
        .N_TURN (N_TURN),
        .N_WP   (N_WP),
        .N_DH   (N_DH),
        .N_GAP  (N_GAP),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .ready     (req_ready),
        .done      (rsp_done),
        .ce_n      (sram_ce_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .drv       (sram_dq_oe)
    );

    sram_ctl_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_ctl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (sram_dq_in),
        .mem_addr  (sram_addr),
        .dq_out    (sram_dq_out),
        .rd_data   (rsp_rdata)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_done)); // R1

    AST_READ_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n)); // R2

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n); // R8

    AST_STROBE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_dq_oe)); // R5

    AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce_n)); // R6

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R11

    AST_BUSY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready); // R9

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

    localparam int P = 8;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + P - 1) / P;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int NRD   = mx(cyc(25), cyc(20));
    localparam int NTURN = cyc(10);
    localparam int NWP   = mx(mx(cyc(20), cyc(20)), cyc(15));
    localparam int NDH   = cyc(2);
    localparam int NGAP  = mx(mx(cyc(5), cyc(20) - NWP - NDH), 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic [18:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = 8'hEE;

    always #4 clk = ~clk;

    sram_ctl u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .req_ready (req_ready), .rsp_rdata (rsp_rdata), .rsp_done (rsp_done),
        .sram_addr (sram_addr), .sram_ce_n (sram_ce_n), .sram_we_n (sram_we_n),
        .sram_oe_n (sram_oe_n), .sram_dq_out (sram_dq_out),
        .sram_dq_oe (sram_dq_oe), .sram_dq_in (sram_dq_in)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // RAM as seen at the pins, and the contents the requests should produce.
    logic [7:0] arr [int];
    logic [7:0] ref_mem [int];
    int rd_cnt = 0;
    logic prev_we = 1'b1;

    function automatic logic [7:0] rd_arr(input int a);
        return arr.exists(a) ? arr[a] : 8'h00;
    endfunction
    function automatic logic [7:0] rd_ref(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    // Behavioural reference: mode 0 idle, 1 read, 2 write; t counts cycles since acceptance.
    int mode = 0;
    int t = 0;
    logic [18:0] m_addr;
    logic [7:0]  m_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= 0;
            t    <= 0;
        end else if (mode == 0) begin
            if (req_valid) begin
                mode   <= req_write ? 2 : 1;
                t      <= 0;
                m_addr <= req_addr;
                m_data <= req_wdata;
                if (req_write) ref_mem[int'(req_addr)] = req_wdata;
            end
        end else begin
            if (t + 1 == ((mode == 1) ? NRD + NTURN : NWP + NDH + NGAP)) mode <= 0;
            t <= t + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (mode == 0) begin
                chk(sram_ce_n && sram_we_n && sram_oe_n, "R1", "idle strobes",
                    {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
                chk(!sram_dq_oe && !rsp_done, "R1", "idle drive/done", {sram_dq_oe, rsp_done}, 0);
                chk(req_ready, "R9", "ready in idle", req_ready, 1);
            end else begin
                chk(!req_ready, "R9", "ready while busy", req_ready, 0);
                if (mode == 1) begin
                    if (t < NRD) begin
                        chk({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe} == 4'b0100, "R2",
                            "read pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b0100);
                        chk(sram_addr == m_addr, "R10", "read addr", sram_addr, m_addr);
                    end else begin
                        chk({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe} == 4'b1110, "R4",
                            "turnaround pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
                    end
                    chk(rsp_done == (t == NRD), "R11", "read done", rsp_done, (t == NRD));
                    if (t == NRD)
                        chk(rsp_rdata == rd_ref(int'(m_addr)), "R3", "read data",
                            rsp_rdata, rd_ref(int'(m_addr)));
                end else begin
                    if (t < NWP) begin
                        chk({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe} == 4'b0011, "R5",
                            "strobe pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b0011);
                        chk(sram_dq_out == m_data, "R5", "write data", sram_dq_out, m_data);
                        chk(sram_addr == m_addr, "R10", "write addr", sram_addr, m_addr);
                    end else if (t < NWP + NDH) begin
                        chk({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe} == 4'b0111, "R6",
                            "hold pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b0111);
                        chk(sram_dq_out == m_data, "R6", "held data", sram_dq_out, m_data);
                    end else begin
                        chk({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe} == 4'b1110, "R7",
                            "recovery pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
                    end
                    chk(rsp_done == (t == NWP), "R6", "write done", rsp_done, (t == NWP));
                end
            end
        end
        // RAM pin model: commit on write-strobe rise, slow read output.
        if (!prev_we && sram_we_n && !sram_ce_n && sram_dq_oe)
            arr[int'(sram_addr)] = sram_dq_out;
        prev_we = sram_we_n;
        if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_cnt++;
        else rd_cnt = 0;
        sram_dq_in <= (rd_cnt >= NRD) ? rd_arr(int'(sram_addr)) : 8'hEE;
    end

    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready && !rsp_done,
            "R1", "reset state", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, rsp_done},
            6'b111010);
        rst_n = 1'b1;
        issue(1'b1, 19'h00000, 8'h5A);
        issue(1'b1, 19'h7FFFF, 8'hFF);
        issue(1'b1, 19'h12345, 8'h00);
        issue(1'b0, 19'h00000, 8'h00);
        issue(1'b0, 19'h7FFFF, 8'h00);
        issue(1'b0, 19'h12345, 8'h00);
        // Busy-time request must be ignored (R9).
        issue(1'b0, 19'h00000, 8'h00);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h0ABCD; req_wdata = 8'hC3;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        issue(1'b0, 19'h0ABCD, 8'h00);
        // Read immediately followed by write, then write followed by read.
        issue(1'b1, 19'h2AAAA, 8'hA5);
        issue(1'b0, 19'h2AAAA, 8'h00);
        issue(1'b1, 19'h2AAAA, 8'h3C);
        issue(1'b0, 19'h2AAAA, 8'h00);
        for (int i = 0; i < 8; i++) issue(1'b1, 19'(i * 4099), 8'(i * 37 + 1));
        for (int i = 0; i < 8; i++) issue(1'b0, 19'(i * 4099), 8'h00);
        repeat (12) @(negedge clk);
        chk(rd_arr(19'h0ABCD) == 8'h00, "R9", "ignored write left memory", rd_arr(19'h0ABCD), 8'h00);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

endmodule